// File: doc/BRIEF.md
# Co-prime Subsampled Scan Observer

This block sits between one scan-chain output of a scan-based self-test and a tester port that cannot keep up with the fast test clock. After a start pulse it checks that the padded sequence length N' and the sample stride P share no common factor. If they do, it refuses the run and flags a configuration error. Otherwise it runs the pattern sequence P times back to back, P·N' fast cycles in total. On every P-th cycle it captures the scan-out bit into a held register that a slow tester can read at leisure.

Because N' and P are co-prime, the P passes together visit every relative time 0..N'-1 exactly once. Each capture is tagged with four values: its observation number, its relative time within the sequence, the scan pattern it belongs to and the cell within that pattern. A pattern occupies L+1 cycles, which is the unload plus one capture cycle. Each capture also carries a mismatch flag against an expected bit. A restart strobe tells the external pattern source when each pass begins. All location values are kept by wrapping counters, with no multiply or divide.

Top module: `subsample_scan_observer`

## Requirements
- R1: After synchronous reset every output is 0.
- R2: On an accepted start, if gcd(N', P) is not 1, or N' or P is 0, `cfg_err` rises and no run takes place: `busy`, `done`, `obs_valid` and `gen_restart` stay 0. `cfg_err` is cleared by the next accepted start.
- R3: Counting run cycles from t = 0, `obs_valid` pulses for one cycle after each cycle with t mod P = 0. With it come `obs_bit` (the `scan_bit` of that cycle) and `obs_err` (`scan_bit` XOR `expect_bit`). All `obs_*` fields hold between pulses.
- R4: For observation i, `obs_rel` = (i·P) mod N', and over the whole run each relative time 0..N'-1 is reported exactly once.
- R5: `obs_pattern` = floor(`obs_rel`/(L+1)) and `obs_cell` = `obs_rel` mod (L+1).
- R6: `gen_restart` is 1 exactly in the run cycles whose relative time is 0, which is P times per run.
- R7: A run lasts exactly P·N' cycles. After it, `busy` is 0 and `done` is 1, and `done` holds until the next accepted start.
- R8: `start` is accepted only when the block is idle or done. A start pulse during the check or the run has no effect.
- R9: `obs_index` starts at 0 and rises by one with each observation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast test clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin the check and then the run |
| cfg_len | input | LEN_W | padded sequence length N' |
| cfg_stride | input | STRIDE_W | sample stride P |
| cfg_chain | input | CELL_W | scan chain length L |
| scan_bit | input | 1 | scan-out bit of the current cycle |
| expect_bit | input | 1 | fault-free value of the current cycle |
| gen_restart | output | 1 | pass begins, pattern source returns to its initial state |
| busy | output | 1 | check or run in progress |
| done | output | 1 | run completed |
| cfg_err | output | 1 | stride and length not co-prime, or zero |
| obs_valid | output | 1 | one-cycle strobe for a new observation |
| obs_bit | output | 1 | held captured bit |
| obs_err | output | 1 | held mismatch flag |
| obs_index | output | LEN_W | observation number |
| obs_rel | output | LEN_W | relative time of the observation |
| obs_pattern | output | LEN_W | failing pattern index |
| obs_cell | output | CELL_W | cell index within the pattern |

## Verification
On every cycle the assertions check the following. The relative time steps by P modulo N' from one observation to the next, and the observation number steps by one. Pattern and cell recombine to the relative time, with the cell never above L. Samples, restarts and errors appear only in the right phases. Only the bench scenarios can show the rest: that the P passes cover every relative time exactly once, the exact cycle of each strobe and of `done`, that the captured bit and mismatch flag come from the right input cycle, and that a start pulse in mid-run is ignored. They compare every cycle with a behavioural model across several (N', P, L) settings, including L = 0 and P = 1, and across refused configurations.

// File: rtl/obs_pkg.sv
package obs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } obs_state_e;
endpackage

// File: rtl/wrap_counter.sv
// Up-counter that returns to zero after reaching a run-time limit.
module wrap_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (en)     cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/coprime_check.sv
// Subtractive Euclid: one step per cycle, single-cycle ready pulse.
module coprime_check #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         ready,
  output logic         coprime
);
  logic [W-1:0] a_q, b_q;
  logic         active;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; b_q <= '0; active <= 1'b0; ready <= 1'b0; coprime <= 1'b0;
    end else if (load) begin
      a_q <= a_in; b_q <= b_in; active <= 1'b1; ready <= 1'b0; coprime <= 1'b0;
    end else if (active) begin
      if (a_q == '0 || b_q == '0) begin
        active <= 1'b0; ready <= 1'b1; coprime <= 1'b0;
      end else if (a_q == b_q) begin
        active <= 1'b0; ready <= 1'b1; coprime <= (a_q == W'(1));
      end else if (a_q > b_q) begin
        a_q <= a_q - b_q;
      end else begin
        b_q <= b_q - a_q;
      end
    end else begin
      ready <= 1'b0;
    end
  end
endmodule

// File: rtl/subsample_scan_observer.sv
module subsample_scan_observer
  import obs_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int STRIDE_W = 6,
  parameter int CELL_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [CELL_W-1:0]   cfg_chain,
  input  logic                scan_bit,
  input  logic                expect_bit,
  output logic                gen_restart,
  output logic                busy,
  output logic                done,
  output logic                cfg_err,
  output logic                obs_valid,
  output logic                obs_bit,
  output logic                obs_err,
  output logic [LEN_W-1:0]    obs_index,
  output logic [LEN_W-1:0]    obs_rel,
  output logic [LEN_W-1:0]    obs_pattern,
  output logic [CELL_W-1:0]   obs_cell
);
  localparam int GCD_W = (LEN_W > STRIDE_W) ? LEN_W : STRIDE_W;

  obs_state_e          state;
  logic [LEN_W-1:0]    len_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [CELL_W-1:0]   chain_q;

  logic start_ok, go_run, run, gcd_ready, gcd_coprime;
  logic rel_last, cell_last, iter_last, run_last, sample;
  logic [LEN_W-1:0]    rel_cnt, pat_cnt, idx_cnt;
  logic [CELL_W-1:0]   cell_cnt;
  logic [STRIDE_W-1:0] phase_cnt, iter_cnt;

  assign start_ok  = start && (state == ST_IDLE || state == ST_DONE);
  assign run       = (state == ST_RUN);
  assign go_run    = (state == ST_CHECK) && gcd_ready && gcd_coprime;
  assign rel_last  = (rel_cnt == len_q - 1'b1);
  assign cell_last = (cell_cnt == chain_q);
  assign iter_last = (iter_cnt == stride_q - 1'b1);
  assign run_last  = run && rel_last && iter_last;
  assign sample    = run && (phase_cnt == '0);

  coprime_check #(.W(GCD_W)) u_gcd (
    .clk(clk), .rst(rst), .load(start_ok),
    .a_in(GCD_W'(cfg_len)), .b_in(GCD_W'(cfg_stride)),
    .ready(gcd_ready), .coprime(gcd_coprime)
  );

  // relative time within the current pass
  wrap_counter #(.W(LEN_W)) u_rel (
    .clk(clk), .rst(rst), .clr(go_run), .en(run),
    .limit(len_q - 1'b1), .cnt(rel_cnt)
  );
  // cell within a pattern: L shift cycles plus one capture cycle
  wrap_counter #(.W(CELL_W)) u_cell (
    .clk(clk), .rst(rst), .clr(go_run || (run && rel_last)), .en(run),
    .limit(chain_q), .cnt(cell_cnt)
  );
  // stride phase: zero marks a sampling cycle
  wrap_counter #(.W(STRIDE_W)) u_phase (
    .clk(clk), .rst(rst), .clr(go_run), .en(run),
    .limit(stride_q - 1'b1), .cnt(phase_cnt)
  );
  // pass counter
  wrap_counter #(.W(STRIDE_W)) u_iter (
    .clk(clk), .rst(rst), .clr(go_run), .en(run && rel_last),
    .limit(stride_q - 1'b1), .cnt(iter_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || go_run || (run && rel_last)) pat_cnt <= '0;
    else if (run && cell_last)              pat_cnt <= pat_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || go_run) idx_cnt <= '0;
    else if (sample)   idx_cnt <= idx_cnt + 1'b1;
  end

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; done <= 1'b0; cfg_err <= 1'b0;
      len_q <= '0; stride_q <= '0; chain_q <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (start_ok) begin
          len_q    <= cfg_len;
          stride_q <= cfg_stride;
          chain_q  <= cfg_chain;
          done     <= 1'b0;
          cfg_err  <= 1'b0;
          state    <= ST_CHECK;
        end
        ST_CHECK: if (gcd_ready) begin
          if (gcd_coprime) state <= ST_RUN;
          else begin
            cfg_err <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_RUN: if (run_last) begin
          done  <= 1'b1;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // held observation register
  always_ff @(posedge clk) begin
    if (rst) begin
      obs_valid <= 1'b0; obs_bit <= 1'b0; obs_err <= 1'b0;
      obs_index <= '0; obs_rel <= '0; obs_pattern <= '0; obs_cell <= '0;
    end else begin
      obs_valid <= sample;
      if (sample) begin
        obs_bit     <= scan_bit;
        obs_err     <= scan_bit ^ expect_bit;
        obs_index   <= idx_cnt;
        obs_rel     <= rel_cnt;
        obs_pattern <= pat_cnt;
        obs_cell    <= cell_cnt;
      end
    end
  end

  assign gen_restart = run && (rel_cnt == '0);
  assign busy        = (state == ST_CHECK) || run;
endmodule

// File: rtl/subsample_scan_observer_chk.sv
module subsample_scan_observer_chk #(
  parameter int LEN_W    = 8,
  parameter int STRIDE_W = 6,
  parameter int CELL_W   = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                done,
  input logic                cfg_err,
  input logic                gen_restart,
  input logic                obs_valid,
  input logic [LEN_W-1:0]    obs_index,
  input logic [LEN_W-1:0]    obs_rel,
  input logic [LEN_W-1:0]    obs_pattern,
  input logic [CELL_W-1:0]   obs_cell,
  input logic [LEN_W-1:0]    len_q,
  input logic [STRIDE_W-1:0] stride_q,
  input logic [CELL_W-1:0]   chain_q
);
  logic [LEN_W-1:0] prev_idx, prev_rel;
  int exp_rel, recomb;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_idx <= '0; prev_rel <= '0;
    end else if (obs_valid) begin
      prev_idx <= obs_index; prev_rel <= obs_rel;
    end
  end

  always_comb begin
    exp_rel = (len_q == '0) ? 0 : (int'(prev_rel) + int'(stride_q)) % int'(len_q);
    recomb  = int'(obs_pattern) * (int'(chain_q) + 1) + int'(obs_cell);
  end

  a_r2_err_no_run: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!busy && !done && !obs_valid && !gen_restart));

  a_r3_valid_after_busy: assert property (@(posedge clk) disable iff (rst)
    obs_valid |-> $past(busy));

  a_r4_rel_stride: assert property (@(posedge clk) disable iff (rst)
    (obs_valid && obs_index != '0) |-> (int'(obs_rel) == exp_rel));

  a_r5_cell_recombine: assert property (@(posedge clk) disable iff (rst)
    obs_valid |-> ((obs_cell <= chain_q) && (recomb == int'(obs_rel))));

  a_r6_restart_in_run: assert property (@(posedge clk) disable iff (rst)
    gen_restart |-> busy);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_index_step: assert property (@(posedge clk) disable iff (rst)
    (obs_valid && obs_index != '0) |-> (obs_index == prev_idx + 1'b1));
endmodule

bind subsample_scan_observer subsample_scan_observer_chk #(
  .LEN_W(LEN_W), .STRIDE_W(STRIDE_W), .CELL_W(CELL_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .cfg_err(cfg_err),
  .gen_restart(gen_restart), .obs_valid(obs_valid), .obs_index(obs_index),
  .obs_rel(obs_rel), .obs_pattern(obs_pattern), .obs_cell(obs_cell),
  .len_q(len_q), .stride_q(stride_q), .chain_q(chain_q)
);

// File: tb/subsample_scan_observer_bench.sv
module subsample_scan_observer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8, STRIDE_W = 6, CELL_W = 5;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [STRIDE_W-1:0] cfg_stride = '0;
  logic [CELL_W-1:0] cfg_chain = '0;
  logic scan_bit = 1'b0, expect_bit = 1'b0;
  logic gen_restart, busy, done, cfg_err, obs_valid, obs_bit, obs_err;
  logic [LEN_W-1:0] obs_index, obs_rel, obs_pattern;
  logic [CELL_W-1:0] obs_cell;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subsample_scan_observer #(.LEN_W(LEN_W), .STRIDE_W(STRIDE_W), .CELL_W(CELL_W)) u_subsample_scan_observer (
    .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len), .cfg_stride(cfg_stride),
    .cfg_chain(cfg_chain), .scan_bit(scan_bit), .expect_bit(expect_bit),
    .gen_restart(gen_restart), .busy(busy), .done(done), .cfg_err(cfg_err),
    .obs_valid(obs_valid), .obs_bit(obs_bit), .obs_err(obs_err), .obs_index(obs_index),
    .obs_rel(obs_rel), .obs_pattern(obs_pattern), .obs_cell(obs_cell)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit golden(input int rel, input int seed);
    return 1'(((rel * 5 + seed) >> 1) & 1);
  endfunction
  function automatic bit fault(input int rel, input int seed);
    return ((rel * 3 + seed) % 4) == 0;
  endfunction

  task automatic run_case(input int n, input int p, input int l, input int seed, input bit poke);
    int seen[256];
    int guard, hrel, hidx, hbit, herr;
    foreach (seen[k]) seen[k] = 0;
    hrel = 0; hidx = 0; hbit = 0; herr = 0;
    cfg_len = LEN_W'(n); cfg_stride = STRIDE_W'(p); cfg_chain = CELL_W'(l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && cfg_err == 1'b0, "R7 done cleared by start", int'(done), 0);
    guard = 0;
    while (!gen_restart && guard < 600) begin
      @(negedge clk); guard++;
    end
    chk(gen_restart == 1'b1, "R6 run begins with restart", int'(gen_restart), 1);
    for (int t = 0; t < p * n; t++) begin
      int rel;
      bit b, e;
      rel = t % n;
      e = golden(rel, seed);
      b = e ^ fault(rel, seed);
      scan_bit = b; expect_bit = e;
      start = (poke && t == (p * n) / 2);
      @(negedge clk);
      start = 1'b0;
      if (t % p == 0) begin
        hrel = rel; hidx = t / p; hbit = b; herr = b ^ e;
        seen[rel]++;
        chk(obs_valid == 1'b1, "R3 strobe on sample", int'(obs_valid), 1);
        chk(int'(obs_index) == hidx, "R9 observation index", int'(obs_index), hidx);
      end else begin
        chk(obs_valid == 1'b0, "R3 no strobe between samples", int'(obs_valid), 0);
      end
      chk(int'(obs_rel) == hrel, "R4 relative time", int'(obs_rel), hrel);
      chk(int'(obs_bit) == hbit, "R3 captured bit", int'(obs_bit), hbit);
      chk(int'(obs_err) == herr, "R3 mismatch flag", int'(obs_err), herr);
      chk(int'(obs_pattern) == hrel / (l + 1), "R5 pattern", int'(obs_pattern), hrel / (l + 1));
      chk(int'(obs_cell) == hrel % (l + 1), "R5 cell", int'(obs_cell), hrel % (l + 1));
      if (t + 1 < p * n) begin
        chk(gen_restart == ((t + 1) % n == 0), "R6 restart timing", int'(gen_restart), int'((t + 1) % n == 0));
        chk(busy == 1'b1 && done == 1'b0, "R7 busy through run (R8 start ignored)", int'(done), 0);
      end else begin
        chk(done == 1'b1 && busy == 1'b0, "R7 done after P*N cycles", int'(done), 1);
        chk(gen_restart == 1'b0, "R6 no restart after run", int'(gen_restart), 0);
      end
    end
    for (int r = 0; r < n; r++)
      chk(seen[r] == 1, "R4 each relative time once", seen[r], 1);
    @(negedge clk);
    chk(done == 1'b1 && obs_valid == 1'b0, "R7 done held", int'(done), 1);
  endtask

  task automatic err_case(input int n, input int p);
    int guard;
    bit bad;
    bad = 1'b0;
    cfg_len = LEN_W'(n); cfg_stride = STRIDE_W'(p); cfg_chain = CELL_W'(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!cfg_err && guard < 600) begin
      if (obs_valid || gen_restart) bad = 1'b1;
      @(negedge clk); guard++;
    end
    chk(cfg_err == 1'b1, "R2 config error raised", int'(cfg_err), 1);
    chk(!bad, "R2 no samples or restarts", int'(bad), 0);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && obs_valid == 1'b0 && gen_restart == 1'b0,
        "R2 no run after error", int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !cfg_err && !obs_valid && !gen_restart && obs_index == '0 &&
        obs_rel == '0 && !obs_bit && !obs_err, "R1 reset state", int'(busy), 0);
    run_case(10, 3, 4, 1, 1'b0);
    run_case(9, 4, 2, 2, 1'b1);   // R8 start pulse mid-run
    err_case(6, 4);               // gcd 2
    run_case(11, 5, 0, 3, 1'b0);  // L = 0
    err_case(5, 0);               // zero stride
    run_case(7, 1, 2, 0, 1'b0);   // P = 1
    run_case(16, 7, 3, 5, 1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule